// File: doc/BRIEF.md
# Amplifier Control Register Target on a Two-Wire Serial Bus

This block is a write-only target on a two-wire serial control bus (I2C style, SCL and SDA). It holds the control state of a mono speaker amplifier. A fast system clock oversamples both bus lines through two-flop synchronizers. The block detects START and STOP conditions, matches the fixed 7-bit address 1101111 with a write direction bit, and acknowledges by asserting an open-drain pull-down enable on SDA. Each data byte after the address carries its own register select in bit 7. A select of 0 updates the mode register: enable, mute and test flag. A select of 1 updates the 6-bit volume code.

From that state the block drives four outputs: an amplifier enable, a mute flag, a test flag and a signed gain figure in dB. The gain figure is decoded from the volume code and is forced to -90 dB while mute is set. An active-low clear input returns all control state to its defaults and blanks the bus while it is held low. Shutdown and mute keep the stored volume, so leaving either mode restores the previous gain. The block applies a byte at the start of its acknowledge slot, and the outputs follow two system clocks later.

Top module: `amp_ctl_i2c_target`

## Requirements
- R1: After `rst`, `amp_en`, `mute_on` and `test_on` are 0, `gain_db` is -90 and `sda_pull_low` is 0.
- R2: An address byte of 0xDE (address 1101111, direction 0, MSB first, sampled on SCL rising) is acknowledged: `sda_pull_low` is 1 while SCL is high in the ninth clock. Any other address is not acknowledged, and the bytes that follow it change nothing.
- R3: An address byte with the direction bit set (0xDF) is not acknowledged, and the block ignores the bus until the next START.
- R4: A data byte with bit 7 = 0 writes the mode register: bit 0 is the enable, bit 1 is mute and bit 4 is the test flag. Bits 2, 3, 5 and 6 have no effect.
- R5: A data byte with bit 7 = 1 writes the volume code from bits 5:0. Bit 6 has no effect.
- R6: With mute clear, `gain_db` decodes the supported codes as follows: 0 gives -90; 1..6 give -25 rising by 3 per step; 7 gives -8; 8..31 give -6 rising by 2 per step; 60..63 give 42, 44, 46 and 48.
- R7: The unsupported codes decode to their aliased values: 32..42 give the same values as codes 0..10; 43 gives 0; 44, 45 and 46 give 4, 8 and 12; 47..59 give 14 rising by 2 per step.
- R8: After one address match, any number of data bytes are each acknowledged and applied in order until STOP.
- R9: After STOP, bus clocks with no START change nothing and are not acknowledged.
- R10: While mute is set, `gain_db` is -90 and the stored volume is kept. Clearing mute restores the gain of that volume.
- R11: While the enable bit is 0, `amp_en` is 0 and the volume is kept. Setting the enable bit again restores the earlier gain.
- R12: While `clr_n` is low, the registers return to their defaults, `amp_en` is 0 and no byte is acknowledged or applied. After `clr_n` rises, the block stays disabled at -90 dB until a register write.
- R13: A repeated START restarts address reception, even when the earlier address was refused.
- R14: `sda_pull_low` is never asserted during the eight data bits of any byte, so the pull-down is released after the ninth clock.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low control clear, synchronous to clk |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| amp_en | output | 1 | Amplifier enable |
| mute_on | output | 1 | Mute flag |
| test_on | output | 1 | Test flag |
| gain_db | output | 8 | Signed effective gain in dB |

## Verification
A bit counter that slips or a wrong frame state shows up at the ports within one byte. The acknowledge appears in the wrong clock, or is missing, and the next applied byte lands in the wrong register or with shifted bits. That is visible on the outputs two system clocks after the acknowledge slot begins. A decode or mute fault shows on `gain_db` after a single volume write, so every code from 0 to 63 is written and compared. Faults in clear handling and in the STOP and idle states show up only as a change in output after bus activity that should have had no effect. For that reason, each ignored transfer is followed by a snapshot of the outputs.

// File: rtl/amp_ctl_pkg.sv
package amp_ctl_pkg;
  localparam int BYTE_BITS = 8;
  localparam int VOL_W     = 6;
  localparam int GAIN_W    = 8;
  localparam logic [6:0] DEV_ADDR = 7'b1101111;
  localparam int SEL_BIT   = 7;
  localparam int EN_BIT    = 0;
  localparam int MUTE_BIT  = 1;
  localparam int TEST_BIT  = 4;
  localparam logic signed [GAIN_W-1:0] MUTE_DB = -8'sd90;

  typedef enum logic [2:0] {
    LK_IDLE, LK_ADDR, LK_AACK, LK_DATA, LK_DACK
  } link_state_t;

  // decode of the lower half of the code space (0..31)
  function automatic int low_gain(input int c);
    if (c == 0)       return -90;
    else if (c <= 6)  return 3 * c - 28;
    else if (c == 7)  return -8;
    else              return 2 * c - 22;
  endfunction

  function automatic logic signed [GAIN_W-1:0] gain_of(input logic [VOL_W-1:0] code);
    int c;
    int g;
    c = int'(code);
    if (c <= 31)      g = low_gain(c);
    else if (c <= 42) g = low_gain(c - 32);
    else if (c <= 46) g = 4 * (c - 43);
    else if (c <= 59) g = 2 * c - 80;
    else              g = 2 * c - 78;
    return GAIN_W'(g);
  endfunction
endpackage

// File: rtl/amp_ctl_sync.sv
module amp_ctl_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '1;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '1;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/amp_ctl_link.sv
module amp_ctl_link
  import amp_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_n,
  input  logic                 scl_s,
  input  logic                 sda_s,
  output logic                 wr_stb,
  output logic [BYTE_BITS-1:0] wr_byte,
  output logic                 ack_oe
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
  localparam logic [BYTE_BITS-1:0] ADDR_WR = {DEV_ADDR, 1'b0};

  logic scl_q, sda_q;
  logic scl_rise, scl_fall, start_c, stop_c;
  link_state_t state;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk) begin
    if (rst || !clr_n) begin
      state  <= LK_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ack_oe <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        state  <= LK_ADDR;
        cnt    <= '0;
        ack_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= LK_IDLE;
        ack_oe <= 1'b0;
      end else begin
        case (state)
          LK_ADDR, LK_DATA: begin
            if (scl_rise && cnt != CNT_FULL) begin
              sh  <= {sh[BYTE_BITS-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              if (state == LK_ADDR) begin
                if (sh == ADDR_WR) begin
                  ack_oe <= 1'b1;
                  state  <= LK_AACK;
                end else begin
                  state  <= LK_IDLE;
                end
              end else begin
                ack_oe <= 1'b1;
                wr_stb <= 1'b1;
                state  <= LK_DACK;
              end
            end
          end
          LK_AACK, LK_DACK: begin
            if (scl_fall) begin
              ack_oe <= 1'b0;
              cnt    <= '0;
              state  <= LK_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_byte = sh;
endmodule

// File: rtl/amp_ctl_regs.sv
module amp_ctl_regs
  import amp_ctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_n,
  input  logic                     wr_stb,
  input  logic [BYTE_BITS-1:0]     wr_byte,
  output logic                     amp_en,
  output logic                     mute_on,
  output logic                     test_on,
  output logic signed [GAIN_W-1:0] gain_db
);
  logic en_r, mute_r, test_r;
  logic [VOL_W-1:0] vol_r;

  always_ff @(posedge clk) begin
    if (rst || !clr_n) begin
      en_r   <= 1'b0;
      mute_r <= 1'b0;
      test_r <= 1'b0;
      vol_r  <= '0;
    end else if (wr_stb) begin
      if (wr_byte[SEL_BIT]) begin
        vol_r <= wr_byte[VOL_W-1:0];
      end else begin
        en_r   <= wr_byte[EN_BIT];
        mute_r <= wr_byte[MUTE_BIT];
        test_r <= wr_byte[TEST_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_en  <= 1'b0;
      mute_on <= 1'b0;
      test_on <= 1'b0;
      gain_db <= MUTE_DB;
    end else begin
      amp_en  <= en_r & clr_n;
      mute_on <= mute_r;
      test_on <= test_r;
      gain_db <= mute_r ? MUTE_DB : gain_of(vol_r);
    end
  end
endmodule

// File: rtl/amp_ctl_i2c_target.sv
module amp_ctl_i2c_target
  import amp_ctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_pull_low,
  output logic                     amp_en,
  output logic                     mute_on,
  output logic                     test_on,
  output logic signed [GAIN_W-1:0] gain_db
);
  logic [1:0] line_s;
  logic wr_stb;
  logic [BYTE_BITS-1:0] wr_byte;

  amp_ctl_sync #(.W(2), .STAGES(2)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (line_s)
  );

  amp_ctl_link i_link (
    .clk     (clk),
    .rst     (rst),
    .clr_n   (clr_n),
    .scl_s   (line_s[1]),
    .sda_s   (line_s[0]),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .ack_oe  (sda_pull_low)
  );

  amp_ctl_regs i_regs (
    .clk     (clk),
    .rst     (rst),
    .clr_n   (clr_n),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .amp_en  (amp_en),
    .mute_on (mute_on),
    .test_on (test_on),
    .gain_db (gain_db)
  );
endmodule

// File: rtl/amp_ctl_chk.sv
module amp_ctl_chk
  import amp_ctl_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     clr_n,
  input logic                     sda_pull_low,
  input logic                     amp_en,
  input logic                     mute_on,
  input logic signed [GAIN_W-1:0] gain_db
);
  // R12: a held clear leaves the outputs at their defaults
  p_clear_defaults_r12: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && $past(!clr_n)) |=> (!amp_en && !mute_on && gain_db == MUTE_DB));

  // R12: no acknowledge is driven while clear is held
  p_clear_no_ack_r12: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> !sda_pull_low);

  // R10: mute forces the floor gain
  p_mute_floor_r10: assert property (@(posedge clk) disable iff (rst)
    mute_on |-> gain_db == MUTE_DB);

  // R6 / R7: every code decodes inside the table span
  p_gain_span_r6: assert property (@(posedge clk) disable iff (rst)
    gain_db >= -8'sd90 && gain_db <= 8'sd48);
endmodule

bind amp_ctl_i2c_target amp_ctl_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .clr_n        (clr_n),
  .sda_pull_low (sda_pull_low),
  .amp_en       (amp_en),
  .mute_on      (mute_on),
  .gain_db      (gain_db)
);

// File: tb/test_amp_ctl_i2c_target.sv
module test_amp_ctl_i2c_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_low, amp_en, mute_on, test_on;
  logic signed [7:0] gain_db;
  logic sda_line;

  assign sda_line = sda_m & ~sda_pull_low;

  always #2 clk = ~clk;

  amp_ctl_i2c_target i_amp_ctl_i2c_target (
    .clk (clk), .rst (rst), .clr_n (clr_n),
    .scl_i (scl_m), .sda_i (sda_line),
    .sda_pull_low (sda_pull_low), .amp_en (amp_en), .mute_on (mute_on),
    .test_on (test_on), .gain_db (gain_db)
  );

  typedef struct { string req; int kind; logic [10:0] exp; } item_t;
  item_t sb[$];
  int n_vec = 0;
  int n_bad = 0;
  int drive_err = 0;
  logic [3:0] ack_v;
  bit done = 0;

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      wait (sb.size() != 0);
      @(negedge clk);
      begin
        item_t it;
        logic [10:0] act;
        it = sb.pop_front();
        if (it.kind == 0) act = {amp_en, mute_on, test_on, gain_db};
        else if (it.kind == 1) act = {7'd0, ack_v};
        else act = 11'(drive_err);
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string r, input int k, input logic [10:0] e);
    item_t it;
    it.req = r; it.kind = k; it.exp = e;
    sb.push_back(it);
    wait (sb.size() == 0);
    tick(1);
  endtask

  task automatic expect_out(input string r, input bit en, input bit mu, input bit te, input int g);
    tick(Q);
    push(r, 0, {en, mu, te, 8'(g)});
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    if (sda_pull_low) drive_err++;   // R14
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ak);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ak = sda_pull_low;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic xfer(input logic [7:0] a, input int n, input logic [7:0] b0,
                      input logic [7:0] b1, input logic [7:0] b2, input bit with_stop);
    bit ak;
    ack_v = '0;
    bus_start();
    send_byte(a, ak); ack_v[0] = ak;
    if (n > 0) begin send_byte(b0, ak); ack_v[1] = ak; end
    if (n > 1) begin send_byte(b1, ak); ack_v[2] = ak; end
    if (n > 2) begin send_byte(b2, ak); ack_v[3] = ak; end
    if (with_stop) bus_stop();
  endtask

  function automatic int ref_gain(input int c);
    if (c == 0 || c == 32) return -90;
    if (c >= 1 && c <= 6) return -25 + 3 * (c - 1);
    if (c >= 33 && c <= 38) return -25 + 3 * (c - 33);
    if (c == 7 || c == 39) return -8;
    if (c >= 8 && c <= 31) return -6 + 2 * (c - 8);
    if (c >= 40 && c <= 42) return -6 + 2 * (c - 40);
    if (c == 43) return 0;
    if (c >= 44 && c <= 46) return 4 + 4 * (c - 44);
    if (c >= 47 && c <= 59) return 14 + 2 * (c - 47);
    return 42 + 2 * (c - 60);
  endfunction

  initial begin
    bit ak;
    tick(5);
    rst = 1'b0;
    tick(4);
    expect_out("R1", 0, 0, 0, -90);
    push("R1", 1, 11'd0);

    // R2: enable write accepted and acknowledged
    xfer(8'hDE, 1, 8'h01, 8'h00, 8'h00, 1);
    push("R2", 1, 11'b0011);
    expect_out("R2", 1, 0, 0, -90);

    // R5 / R6: volume code 11 -> 0 dB
    xfer(8'hDE, 1, 8'h8B, 8'h00, 8'h00, 1);
    expect_out("R5", 1, 0, 0, 0);

    // R4: reserved mode bits set, test bit clear
    xfer(8'hDE, 1, 8'h6D, 8'h00, 8'h00, 1);
    expect_out("R4", 1, 0, 0, 0);
    // R5: bit 6 of the volume byte ignored (0xD0 -> code 16 = 10 dB)
    xfer(8'hDE, 1, 8'hD0, 8'h00, 8'h00, 1);
    expect_out("R5", 1, 0, 0, 10);

    // R8 / R10: multi-byte: enable+mute+test, then volume 63, then unmute
    xfer(8'hDE, 3, 8'h13, 8'hBF, 8'h01, 1);
    push("R8", 1, 11'b1111);
    expect_out("R8", 1, 0, 0, 48);
    xfer(8'hDE, 1, 8'h13, 8'h00, 8'h00, 1);
    expect_out("R10", 1, 1, 1, -90);
    xfer(8'hDE, 1, 8'h01, 8'h00, 8'h00, 1);
    expect_out("R10", 1, 0, 0, 48);

    // R2: wrong address is refused and its data ignored
    xfer(8'hBC, 1, 8'h80, 8'h00, 8'h00, 1);
    push("R2", 1, 11'b0000);
    expect_out("R2", 1, 0, 0, 48);

    // R3: read direction refused and ignored
    xfer(8'hDF, 2, 8'h80, 8'h00, 8'h00, 1);
    push("R3", 1, 11'b0000);
    expect_out("R3", 1, 0, 0, 48);

    // R9: clocks after STOP without START
    ack_v = '0;
    send_byte(8'hDE, ak); ack_v[0] = ak;
    send_byte(8'h80, ak); ack_v[1] = ak;
    push("R9", 1, 11'b0000);
    expect_out("R9", 1, 0, 0, 48);

    // R11: shutdown keeps volume, re-enable restores
    xfer(8'hDE, 1, 8'h00, 8'h00, 8'h00, 1);
    expect_out("R11", 0, 0, 0, 48);
    xfer(8'hDE, 1, 8'h01, 8'h00, 8'h00, 1);
    expect_out("R11", 1, 0, 0, 48);

    // R13: refused address, repeated START, then a good address
    xfer(8'hBC, 0, 8'h00, 8'h00, 8'h00, 0);
    xfer(8'hDE, 1, 8'h87, 8'h00, 8'h00, 1);
    push("R13", 1, 11'b0011);
    expect_out("R13", 1, 0, 0, -8);
    // R13: good address, repeated START mid-transfer, new frame applies
    xfer(8'hDE, 1, 8'h85, 8'h00, 8'h00, 0);
    xfer(8'hDE, 1, 8'h88, 8'h00, 8'h00, 1);
    expect_out("R13", 1, 0, 0, -6);

    // R6 / R7: sweep every volume code
    for (int c = 0; c < 64; c++) begin
      xfer(8'hDE, 1, {2'b10, 6'(c)}, 8'h00, 8'h00, 1);
      expect_out((c >= 32 && c <= 59) ? "R7" : "R6", 1, 0, 0, ref_gain(c));
    end

    // R12: clear held during a write
    clr_n = 1'b0;
    xfer(8'hDE, 1, 8'h81, 8'h00, 8'h00, 1);
    push("R12", 1, 11'b0000);
    expect_out("R12", 0, 0, 0, -90);
    clr_n = 1'b1;
    expect_out("R12", 0, 0, 0, -90);
    xfer(8'hDE, 1, 8'h01, 8'h00, 8'h00, 1);
    expect_out("R12", 1, 0, 0, -90);

    // R14: pull-down never seen during data bits
    push("R14", 2, 11'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule